// File: doc/BRIEF.md
# Modulo Up-Counter Alarm Timer

This block is a 16-bit up-counter used as a one-shot or repeating alarm source. A system-clock-synchronous tick enable, at a fixed low frequency, is divided by a power-of-two prescaler. Each resulting count event advances the counter. When the counter has reached the programmed modulo value, the next event reloads it with a programmable initial value instead of wrapping to zero. That reload is an overflow. The overflow flag can be set on every overflow, or only on every (N+1)-th overflow. A level interrupt follows the flag when interrupts are enabled.

Software reaches the timer through a plain 32-bit register port: address, read strobe, write strobe, write data and combinational read data. For a one-shot alarm, software programs the modulo value to the number of events minus one. It then loads the counter, starts the count source and waits for the interrupt. To clear the flag, software reads the control register and then writes 0 to the flag bit. An overflow that lands on the same cycle as a clear keeps the flag set.

Top module: `alarm_timer`

## Requirements
- R1: After reset, every register (0x00, 0x04, 0x08, 0x0C, 0x10) reads zero and `irq` is 0.
- R2: Control register 0x00 holds the prescale field in bits 2:0 and the source select in bits 4:3. With source select 2, the counter advances once per 2^prescale cycles in which `tick_en` is 1. A write to 0x00 restarts the divider, so the first advance comes exactly 2^prescale ticks after the write. With `tick_en` held at 0, the counter does not move.
- R3: A count event that finds the counter equal to the modulo value (0x08) loads the initial value (0x0C) instead of incrementing. Any other count event adds one.
- R4: With source select 0, 1 or 3, the counter holds its value.
- R5: A write of any data to 0x04 loads the counter with the initial value.
- R6: Registers 0x04, 0x08 and 0x0C keep only their low 16 bits, and bits 31:16 read as zero. The config register 0x10 keeps bits 4:0 as the overflow threshold N.
- R7: The overflow flag is bit 7 of 0x00. With N = 0 it is set on every overflow. With N > 0 it is set on every (N+1)-th overflow counted since reset.
- R8: Writing 1 to bit 7 never changes the flag. Writing 0 clears the flag only if the previous access to 0x00 was a read that returned the flag as 1. Without that read, the flag stays set.
- R9: If an overflow that sets the flag coincides with a valid clear, the flag stays 1. A later read-then-write-0 still clears it.
- R10: `irq` is 1 exactly while the flag and the interrupt enable (bit 6 of 0x00) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Single-cycle fixed-frequency tick enable |
| bus_rd | input | 1 | Read strobe, arms a flag clear when reading 0x00 |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the counter is loaded only by a count-register write or by a count event. They also assume that a register write and a read of the same address may share a cycle, and that the write then decides the arming state. The stimulus issues at most one register access per cycle and drives it half a cycle before the capturing edge. It changes the count source only through whole-register writes, so the prescaler restart always coincides with a known edge. The collision case is aimed by peeking the counter at the negative edge and issuing the clear write only when the counter equals the modulo value with a divide-by-one prescaler.

// File: rtl/alarm_timer_pkg.sv
package alarm_timer_pkg;

  localparam int BUS_W = 32;

  // register offsets (byte addresses)
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_COUNT = 8'h04;
  localparam logic [7:0] OFS_MOD   = 8'h08;
  localparam logic [7:0] OFS_INIT  = 8'h0C;
  localparam logic [7:0] OFS_CFG   = 8'h10;

  // control register field positions
  localparam int CTL_PS_LSB = 0;
  localparam int CTL_CS_LSB = 3;
  localparam int CTL_TOIE   = 6;
  localparam int CTL_TOF    = 7;

  typedef enum logic [1:0] {
    CS_OFF    = 2'd0,
    CS_RSVD_A = 2'd1,
    CS_TICK   = 2'd2,
    CS_RSVD_B = 2'd3
  } clk_sel_e;

  // last divider state before a count event for a given prescale code
  function automatic logic [31:0] div_limit(input logic [31:0] ps);
    return (32'd1 << ps) - 32'd1;
  endfunction

  // counter successor for one count event
  function automatic logic [31:0] next_count(input logic [31:0] cur,
                                             input logic [31:0] modv,
                                             input logic [31:0] init);
    return (cur == modv) ? init : cur + 32'd1;
  endfunction

endpackage

// File: rtl/at_prescaler.sv
module at_prescaler
  import alarm_timer_pkg::*;
#(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] ps,
  output logic            step
);

  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  assign lim  = DIV_W'(div_limit(32'(ps)));
  assign step = run && tick_en && (div_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (restart) begin
      div_q <= '0;
    end else if (run && tick_en) begin
      div_q <= step ? '0 : div_q + 1'b1;
    end
  end

endmodule

// File: rtl/at_counter.sv
module at_counter
  import alarm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] init,
  input  logic [CNT_W-1:0] modv,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);

  assign wrap = step && !load && (cnt_q == modv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= init;
    end else if (step) begin
      cnt_q <= CNT_W'(next_count(32'(cnt_q), 32'(modv), 32'(init)));
    end
  end

endmodule

// File: rtl/at_tof.sv
module at_tof #(
  parameter int NUMTOF_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrap,
  input  logic [NUMTOF_W-1:0] numtof,
  input  logic                ctrl_rd,
  input  logic                ctrl_wr,
  input  logic                wr_tof_bit,
  output logic                tof_q,
  output logic                tof_set,
  output logic                clr_ok
);

  logic [NUMTOF_W-1:0] ovf_q;
  logic                armed_q;

  assign tof_set = wrap && (ovf_q >= numtof);
  assign clr_ok  = ctrl_wr && armed_q && !wr_tof_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q   <= '0;
      tof_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wrap) begin
        ovf_q <= tof_set ? '0 : ovf_q + 1'b1;
      end
      if (tof_set) begin
        tof_q <= 1'b1;
      end else if (clr_ok) begin
        tof_q <= 1'b0;
      end
      if (ctrl_wr) begin
        armed_q <= 1'b0;
      end else if (ctrl_rd && tof_q) begin
        armed_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/alarm_timer.sv
module alarm_timer
  import alarm_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PS_W     = 3,
  parameter int NUMTOF_W = 5,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  // control and configuration state
  logic [PS_W-1:0]     ps_q;
  clk_sel_e            cs_q;
  logic                toie_q;
  logic [CNT_W-1:0]    mod_q;
  logic [CNT_W-1:0]    init_q;
  logic [NUMTOF_W-1:0] numtof_q;

  // named internal events
  logic             sel_ctrl, sel_cnt, sel_mod, sel_init, sel_cfg;
  logic             ctrl_wr, ctrl_rd, cnt_wr, mod_wr, init_wr, cfg_wr;
  logic             run, step, wrap;
  logic             tof_q, tof_set, clr_ok;
  logic [CNT_W-1:0] cnt_q;
  logic             unused_wdata;

  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_cnt  = (bus_addr == ADDR_W'(OFS_COUNT));
  assign sel_mod  = (bus_addr == ADDR_W'(OFS_MOD));
  assign sel_init = (bus_addr == ADDR_W'(OFS_INIT));
  assign sel_cfg  = (bus_addr == ADDR_W'(OFS_CFG));

  assign ctrl_wr = bus_wr && sel_ctrl;
  assign ctrl_rd = bus_rd && sel_ctrl;
  assign cnt_wr  = bus_wr && sel_cnt;
  assign mod_wr  = bus_wr && sel_mod;
  assign init_wr = bus_wr && sel_init;
  assign cfg_wr  = bus_wr && sel_cfg;

  assign run = (cs_q == CS_TICK);

  assign unused_wdata = ^bus_wdata[BUS_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q     <= '0;
      cs_q     <= CS_OFF;
      toie_q   <= 1'b0;
      mod_q    <= '0;
      init_q   <= '0;
      numtof_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ps_q   <= bus_wdata[CTL_PS_LSB +: PS_W];
        cs_q   <= clk_sel_e'(bus_wdata[CTL_CS_LSB +: 2]);
        toie_q <= bus_wdata[CTL_TOIE];
      end
      if (mod_wr) begin
        mod_q <= bus_wdata[CNT_W-1:0];
      end
      if (init_wr) begin
        init_q <= bus_wdata[CNT_W-1:0];
      end
      if (cfg_wr) begin
        numtof_q <= bus_wdata[NUMTOF_W-1:0];
      end
    end
  end

  at_prescaler #(.PS_W(PS_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .run     (run),
    .restart (ctrl_wr),
    .ps      (ps_q),
    .step    (step)
  );

  at_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .load  (cnt_wr),
    .init  (init_q),
    .modv  (mod_q),
    .cnt_q (cnt_q),
    .wrap  (wrap)
  );

  at_tof #(.NUMTOF_W(NUMTOF_W)) u_tof (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrap       (wrap),
    .numtof     (numtof_q),
    .ctrl_rd    (ctrl_rd),
    .ctrl_wr    (ctrl_wr),
    .wr_tof_bit (bus_wdata[CTL_TOF]),
    .tof_q      (tof_q),
    .tof_set    (tof_set),
    .clr_ok     (clr_ok)
  );

  assign irq = tof_q && toie_q;

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[CTL_PS_LSB +: PS_W] = ps_q;
      bus_rdata[CTL_CS_LSB +: 2]    = cs_q;
      bus_rdata[CTL_TOIE]           = toie_q;
      bus_rdata[CTL_TOF]            = tof_q;
    end else if (sel_cnt) begin
      bus_rdata[CNT_W-1:0] = cnt_q;
    end else if (sel_mod) begin
      bus_rdata[CNT_W-1:0] = mod_q;
    end else if (sel_init) begin
      bus_rdata[CNT_W-1:0] = init_q;
    end else if (sel_cfg) begin
      bus_rdata[NUMTOF_W-1:0] = numtof_q;
    end
  end

endmodule

// File: rtl/at_checker.sv
module at_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] init_q,
  input logic             cnt_wr,
  input logic             run,
  input logic             wrap,
  input logic             tof_q,
  input logic             tof_set,
  input logic             clr_ok,
  input logic             ctrl_wr,
  input logic             toie_q,
  input logic             irq
);

  // R5: a count-register write lands the initial value
  p_load_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(init_q)));

  // R4: a stopped source keeps the counter still
  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt_q));

  // R3: an overflow reloads the initial value
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == $past(init_q)));

  // R7 and R9: a qualifying overflow always leaves the flag set
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tof_set |=> tof_q);

  // R8: an accepted clear without a competing set drops the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ok && !tof_set) |=> !tof_q);

  // R8: a control write never raises the flag by itself
  p_no_w1_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !tof_q && !tof_set) |=> !tof_q);

  // R10: interrupt only with flag and enable
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tof_q && toie_q));

endmodule

bind alarm_timer at_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt_q   (cnt_q),
  .init_q  (init_q),
  .cnt_wr  (cnt_wr),
  .run     (run),
  .wrap    (wrap),
  .tof_q   (tof_q),
  .tof_set (tof_set),
  .clr_ok  (clr_ok),
  .ctrl_wr (ctrl_wr),
  .toie_q  (toie_q),
  .irq     (irq)
);

// File: tb/alarm_timer_tb_top.sv
module alarm_timer_tb_top;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_CNT  = 5'h04;
  localparam logic [4:0] A_MOD  = 5'h08;
  localparam logic [4:0] A_INIT = 5'h0C;
  localparam logic [4:0] A_CFG  = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  alarm_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  function automatic logic [31:0] ctl(int cs, int ps, int toie, int tof);
    return 32'((tof << 7) | (toie << 6) | (cs << 3) | ps);
  endfunction

  // counter value and overflow count after n events from a fresh load
  function automatic int model_cnt(int init, int modv, int n, output int ovf);
    int v = init;
    ovf = 0;
    for (int k = 0; k < n; k++) begin
      if (v == modv) begin
        v = init;
        ovf++;
      end else begin
        v = (v + 1) & 16'hFFFF;
      end
    end
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    bus_rd  = 1'b0;
    bus_wr  = 1'b0;
    tick_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic peek(logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic setup(int init, int modv, int numtof);
    do_reset();
    wr(A_CFG, 32'(numtof));
    wr(A_MOD, 32'(modv));
    wr(A_INIT, 32'(init));
    wr(A_CNT, 32'hDEAD_BEEF);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int ovf, ev;
    bit found;

    // R1: reset state
    do_reset();
    peek(A_CTRL, d); check("R1 ctrl", d, 0);
    peek(A_CNT,  d); check("R1 count", d, 0);
    peek(A_MOD,  d); check("R1 mod", d, 0);
    peek(A_INIT, d); check("R1 init", d, 0);
    peek(A_CFG,  d); check("R1 cfg", d, 0);
    check("R1 irq", 32'(irq), 0);

    // R2, R3, R5, R7: sweep prescale and modulo/initial pairs
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 3; c++) begin
        int iv = (c == 0) ? 0 : (c == 1) ? 3 : 7;
        int mv = (c == 0) ? 5 : (c == 1) ? 9 : 7;
        setup(iv, mv, 0);
        peek(A_CNT, d); check("R5 load on count write", d, 32'(iv));
        wr(A_CTRL, ctl(2, p, 0, 0));
        repeat (11 << p) @(posedge clk);
        peek(A_CNT, d);
        check("R2 R3 count after 11 events", d, 32'(model_cnt(iv, mv, 11, ovf)));
        peek(A_CTRL, d);
        check("R7 flag after 11 events", 32'(d[7]), 32'(ovf >= 1));
      end
    end

    // R2: one tick short of the first event with prescale 3
    setup(0, 100, 0);
    wr(A_CTRL, ctl(2, 3, 0, 0));
    repeat (7) @(posedge clk);
    peek(A_CNT, d); check("R2 no event before 2^ps ticks", d, 0);
    @(posedge clk);
    peek(A_CNT, d); check("R2 event at 2^ps ticks", d, 1);

    // R2: no ticks, no counting
    setup(4, 100, 0);
    tick_en = 1'b0;
    wr(A_CTRL, ctl(2, 0, 0, 0));
    repeat (20) @(posedge clk);
    peek(A_CNT, d); check("R2 tick_en low holds", d, 4);
    tick_en = 1'b1;

    // R4: non-tick sources hold the counter
    for (int cs = 0; cs < 4; cs += 1) begin
      if (cs != 2) begin
        setup(4, 100, 0);
        wr(A_CTRL, ctl(cs, 0, 0, 0));
        repeat (20) @(posedge clk);
        peek(A_CNT, d); check("R4 stopped source holds", d, 4);
      end
    end

    // R6: upper bits read zero
    do_reset();
    wr(A_MOD, 32'hFFFF_FFFF);
    wr(A_INIT, 32'hA5A5_1234);
    wr(A_CFG, 32'hFFFF_FFFF);
    wr(A_CNT, 32'h0);
    peek(A_MOD, d);  check("R6 mod width", d, 32'h0000_FFFF);
    peek(A_INIT, d); check("R6 init width", d, 32'h0000_1234);
    peek(A_CNT, d);  check("R6 count width", d, 32'h0000_1234);
    peek(A_CFG, d);  check("R6 cfg width", d, 32'h0000_001F);

    // R7: overflow threshold N = 0..3, modulo 1 => overflow every 2 events
    for (int n = 0; n < 4; n++) begin
      setup(0, 1, n);
      wr(A_CTRL, ctl(2, 0, 0, 0));
      ev = 2 * (n + 1) - 1;
      repeat (ev) @(posedge clk);
      peek(A_CTRL, d); check("R7 flag one event early", 32'(d[7]), 0);
      @(posedge clk);
      peek(A_CTRL, d); check("R7 flag at N+1 overflows", 32'(d[7]), 1);
    end

    // R8, R10: clear protocol and interrupt gating
    setup(0, 2, 0);
    wr(A_CTRL, ctl(2, 0, 1, 0));
    repeat (5) @(posedge clk);
    peek(A_CTRL, d); check("R7 flag set", 32'(d[7]), 1);
    check("R10 irq with flag and enable", 32'(irq), 1);
    wr(A_CTRL, ctl(0, 0, 1, 1));
    peek(A_CTRL, d); check("R8 write 1 keeps flag", 32'(d[7]), 1);
    wr(A_CTRL, ctl(0, 0, 1, 0));
    peek(A_CTRL, d); check("R8 clear without read ignored", 32'(d[7]), 1);
    rd(A_CTRL, d);
    wr(A_CTRL, ctl(0, 0, 1, 0));
    peek(A_CTRL, d); check("R8 read then clear", 32'(d[7]), 0);
    check("R10 irq drops with flag", 32'(irq), 0);
    wr(A_CTRL, ctl(0, 0, 1, 1));
    peek(A_CTRL, d); check("R8 write 1 does not set", 32'(d[7]), 0);
    setup(0, 2, 0);
    wr(A_CTRL, ctl(2, 0, 0, 0));
    repeat (5) @(posedge clk);
    peek(A_CTRL, d); check("R10 flag set, enable off", 32'(d[7]), 1);
    check("R10 irq stays low without enable", 32'(irq), 0);

    // R9: clear collides with an overflow
    setup(0, 3, 0);
    wr(A_CTRL, ctl(2, 0, 0, 0));
    repeat (6) @(posedge clk);
    rd(A_CTRL, d);
    check("R9 flag before collision", 32'(d[7]), 1);
    found = 1'b0;
    for (int k = 0; k < 20 && !found; k++) begin
      @(negedge clk);
      bus_addr = A_CNT;
      #1 if (bus_rdata == 32'd3) found = 1'b1;
    end
    check("R9 collision point found", 32'(found), 1);
    bus_addr  = A_CTRL;
    bus_wdata = ctl(2, 0, 0, 0);
    bus_wr    = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    peek(A_CTRL, d); check("R9 set wins over clear", 32'(d[7]), 1);
    wr(A_CTRL, ctl(0, 0, 0, 1));
    rd(A_CTRL, d);
    wr(A_CTRL, ctl(0, 0, 0, 0));
    peek(A_CTRL, d); check("R9 later clear succeeds", 32'(d[7]), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule